// File: doc/BRIEF.md
# Packed Element Bit Count and Fill Unit

This unit executes the two-operand vector operations that work on one 128-bit source vector. The vector is split into equal elements of 8, 16, 32 or 64 bits, chosen by a format field in the instruction word. Three of the operations work on each element on its own: they count leading zeros, count leading ones, or count the bits that are set. The count is zero-extended to the full element width. The fourth operation ignores the source vector. It takes a scalar register value, cuts it down to the element width and copies it into every element of the result.

Every element is worked on in parallel, and the outputs are registered. An accepted instruction gives its result, the write enable, the destination index, a reserved-instruction flag and a one-hot modify-mask update on the cycle after the input was valid. The register file and the exception path sit outside this unit. A side input says whether the machine is in 64-bit scalar mode. Filling 64-bit elements is illegal when that mode is off.

Top module: `vbc_unit`

## Requirements
- R1: The instruction is accepted only when bits [5:0] equal 6'h1E and bits [25:21] equal 5'h18. Bits [20:18] select the operation: 0 fill, 1 set-bit count, 2 leading-one count, 3 leading-zero count. Bits [17:16] select the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Bits [10:6] give the destination index.
- R2: The leading-zero count returns, for each element, the number of zero bits above the highest set bit, zero-extended into that element. An all-zero element gives the element width.
- R3: The leading-one count returns the number of one bits above the highest clear bit of each element. An all-ones element gives the element width.
- R4: The set-bit count returns the number of ones in each element, zero-extended into that element.
- R5: Fill copies the low element-width bits of the 64-bit scalar input into every element of the result. Fill with 64-bit elements is legal when `wide_mode_i` is 1.
- R6: Fill with 64-bit elements while `wide_mode_i` is 0 sets `resv_instr_o`. In that case `wr_en_o` stays 0 and the modify mask stays 0.
- R7: An instruction whose group does not match, or whose operation value is 4 to 7, sets neither `wr_en_o` nor `resv_instr_o`. While `wr_en_o` is 0, `result_o` is zero.
- R8: `out_valid_o`, `wr_en_o`, `resv_instr_o`, `result_o`, `wr_idx_o` and `modify_set_o` belong to the input presented one cycle earlier. They are all zero when no input was valid.
- R9: When `track_en_i` is 1 and the result is written, `modify_set_o` has only the bit at the destination index set. Otherwise it is zero.
- R10: While reset is asserted, and on the first cycles after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| src_vec_i | input | 128 | Source vector |
| scalar_i | input | 64 | Scalar register value for fill |
| wide_mode_i | input | 1 | 64-bit scalar mode is active |
| track_en_i | input | 1 | Write tracking is enabled |
| out_valid_o | output | 1 | Outputs belong to an accepted input |
| result_o | output | 128 | Result vector |
| wr_en_o | output | 1 | Write the result to the destination |
| wr_idx_o | output | 5 | Destination register index |
| resv_instr_o | output | 1 | Reserved-instruction indication |
| modify_set_o | output | 32 | Bits to set in the modify mask |

## Verification
Every output register loads again on each cycle. A wrong decode, a wrong format select or a wrong count therefore shows up at the ports on the cycle right after the input that caused it, and it does not carry over into later results. The directed cases aim at the values that break counting logic most easily: all-zero and all-ones elements, a single set bit at the top or at the bottom, and patterns that differ between neighbouring elements. A format mux that picks the wrong width therefore shows as wrong element boundaries straight away. The illegal 64-bit fill, operation values outside the defined set, and switching tracking off are each checked through the write enable, the reserved-instruction flag and the modify mask on the cycle they appear.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  localparam logic [5:0] MINOR_CODE = 6'h1E;
  localparam logic [4:0] GROUP_CODE = 5'h18;
  localparam int unsigned NUM_FMT = 4;

  typedef enum logic [2:0] {
    OP_FILL = 3'd0,
    OP_POP  = 3'd1,
    OP_LEAD1 = 3'd2,
    OP_LEAD0 = 3'd3
  } op_e;

  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_16 = 2'd1,
    FMT_32 = 2'd2,
    FMT_64 = 2'd3
  } fmt_e;
endpackage

// File: rtl/vbc_clz.sv
module vbc_clz #(
  parameter int W = 8,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0] probe;
  int           remain;

  // binary search: halve the step until one bit remains
  always_comb begin
    probe  = val_i;
    remain = W;
    for (int step = W / 2; step > 0; step = step / 2) begin
      if ((probe >> step) != '0) begin
        remain = remain - step;
        probe  = probe >> step;
      end
    end
    cnt_o = CW'(remain - int'(probe[0]));
  end
endmodule

// File: rtl/vbc_popcnt.sv
module vbc_popcnt #(
  parameter int W = 8,
  localparam int CW = $clog2(W) + 1,
  localparam int NST = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  function automatic logic [W-1:0] field_mask(int fw);
    logic [W-1:0] m;
    for (int b = 0; b < W; b++) m[b] = ((b / fw) % 2) == 0;
    return m;
  endfunction

  logic [W-1:0] sums [NST+1];
  assign sums[0] = val_i;

  for (genvar s = 0; s < NST; s++) begin : g_stage
    localparam int FW = 1 << s;
    localparam logic [W-1:0] MASK = field_mask(FW);
    assign sums[s+1] = (sums[s] & MASK) + ((sums[s] >> FW) & MASK);
  end

  assign cnt_o = sums[NST][CW-1:0];
endmodule

// File: rtl/vbc_decode.sv
module vbc_decode
  import vbc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      instr_i,
  input  logic             wide_mode_i,
  output logic             write_o,
  output logic             resv_o,
  output logic             is_fill_o,
  output logic             is_pop_o,
  output logic             is_lead1_o,
  output fmt_e             fmt_o,
  output logic [IDX_W-1:0] dst_o
);
  logic       grp_hit;
  logic [2:0] sub;
  logic       known;
  logic       bad_fill;

  always_comb begin
    grp_hit    = (instr_i[5:0] == MINOR_CODE) && (instr_i[25:21] == GROUP_CODE);
    sub        = instr_i[20:18];
    fmt_o      = fmt_e'(instr_i[17:16]);
    dst_o      = instr_i[6 +: IDX_W];
    known      = (sub <= 3'(OP_LEAD0));
    is_fill_o  = grp_hit && (sub == 3'(OP_FILL));
    is_pop_o   = sub == 3'(OP_POP);
    is_lead1_o = sub == 3'(OP_LEAD1);
    bad_fill   = is_fill_o && (fmt_o == FMT_64) && !wide_mode_i;
    resv_o     = bad_fill;
    write_o    = grp_hit && known && !bad_fill;
  end

  AST_RESV_ONLY_WIDE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_o |-> (instr_i[17:16] == 2'd3) && (instr_i[20:18] == 3'd0) && !wide_mode_i); // R6
endmodule

// File: rtl/vbc_unit.sv
module vbc_unit
  import vbc_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int SW    = 64,
  parameter int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [31:0]      instr_i,
  input  logic [VLEN-1:0]  src_vec_i,
  input  logic [SW-1:0]    scalar_i,
  input  logic             wide_mode_i,
  input  logic             track_en_i,
  output logic             out_valid_o,
  output logic [VLEN-1:0]  result_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             resv_instr_o,
  output logic [NREG-1:0]  modify_set_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  // decode
  logic             d_write, d_resv, d_fill, d_pop, d_lead1;
  fmt_e             d_fmt;
  logic [IDX_W-1:0] d_dst;

  vbc_decode #(.IDX_W(IDX_W)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .instr_i    (instr_i),
    .wide_mode_i(wide_mode_i),
    .write_o    (d_write),
    .resv_o     (d_resv),
    .is_fill_o  (d_fill),
    .is_pop_o   (d_pop),
    .is_lead1_o (d_lead1),
    .fmt_o      (d_fmt),
    .dst_o      (d_dst)
  );

  // per-format element datapaths
  logic [NUM_FMT-1:0][VLEN-1:0] cnt_vec;
  logic [NUM_FMT-1:0][VLEN-1:0] fill_vec;

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    localparam int EW = 8 << f;
    localparam int NE = VLEN / EW;
    localparam int CW = $clog2(EW) + 1;

    for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [EW-1:0] elem;
      logic [EW-1:0] lead_in;
      logic [CW-1:0] lead_cnt;
      logic [CW-1:0] pop_cnt;

      assign elem    = src_vec_i[e*EW +: EW];
      assign lead_in = d_lead1 ? ~elem : elem;

      vbc_clz #(.W(EW)) u_clz (
        .val_i(lead_in),
        .cnt_o(lead_cnt)
      );

      vbc_popcnt #(.W(EW)) u_pop (
        .val_i(elem),
        .cnt_o(pop_cnt)
      );

      assign cnt_vec[f][e*EW +: EW] = {{(EW-CW){1'b0}}, (d_pop ? pop_cnt : lead_cnt)};
    end

    assign fill_vec[f] = {NE{scalar_i[EW-1:0]}};
  end

  // next state
  logic             nxt_valid, nxt_wr, nxt_resv;
  logic [VLEN-1:0]  nxt_res;
  logic [NREG-1:0]  nxt_mod;
  logic             idx_en;

  always_comb begin
    nxt_valid = in_valid_i;
    nxt_wr    = in_valid_i && d_write;
    nxt_resv  = in_valid_i && d_resv;
    nxt_res   = '0;
    if (nxt_wr) nxt_res = d_fill ? fill_vec[d_fmt] : cnt_vec[d_fmt];
    nxt_mod   = (nxt_wr && track_en_i) ? (NREG'(1) << d_dst) : '0;
    idx_en    = in_valid_i || out_valid_o;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o  <= 1'b0;
      wr_en_o      <= 1'b0;
      resv_instr_o <= 1'b0;
      result_o     <= '0;
      modify_set_o <= '0;
    end else begin
      out_valid_o  <= nxt_valid;
      wr_en_o      <= nxt_wr;
      resv_instr_o <= nxt_resv;
      result_o     <= nxt_res;
      modify_set_o <= nxt_mod;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      wr_idx_o <= '0;
    else if (idx_en) wr_idx_o <= in_valid_i ? d_dst : '0;
  end

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_valid_i |=> out_valid_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o && !wr_en_o && !resv_instr_o); // R8
  AST_RESV_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    resv_instr_o |-> !wr_en_o && (modify_set_o == '0)); // R6
  AST_MODIFY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(modify_set_o)); // R9
  AST_MODIFY_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (modify_set_o != '0) |-> wr_en_o); // R9
  AST_NO_WRITE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_o |-> (result_o == '0)); // R7
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_o |-> out_valid_o); // R8
endmodule

// File: tb/vbc_unit_bench.sv
`timescale 1ns/1ps
module vbc_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src;
  logic [63:0]  scalar;
  logic         wide;
  logic         track;
  logic         out_valid;
  logic [127:0] result;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic         resv;
  logic [31:0]  modset;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vbc_unit u_vbc_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .instr_i(instr),
    .src_vec_i(src), .scalar_i(scalar), .wide_mode_i(wide), .track_en_i(track),
    .out_valid_o(out_valid), .result_o(result), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .resv_instr_o(resv), .modify_set_o(modset)
  );

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [1:0] fmt,
                                     input logic [4:0] dst);
    return {6'd0, 5'h18, op, fmt, 5'd7, dst, 6'h1E};
  endfunction

  // independent model: scan bits of each element
  function automatic logic [127:0] model(input int op, input int fmt,
                                         input logic [127:0] v, input logic [63:0] s);
    logic [127:0] r;
    int w, n, cnt;
    bit stop;
    r = '0;
    w = 8 << fmt;
    n = 128 / w;
    for (int e = 0; e < n; e++) begin
      cnt = 0;
      stop = 0;
      if (op == 0) begin
        for (int b = 0; b < w; b++) r[e*w+b] = s[b];
      end else begin
        for (int b = w - 1; b >= 0; b--) begin
          if (op == 1) cnt += int'(v[e*w+b]);
          else if (!stop) begin
            if (v[e*w+b] == (op == 2)) cnt++;
            else stop = 1;
          end
        end
        for (int b = 0; b < w; b++) r[e*w+b] = (b < 32) ? cnt[b] : 1'b0;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // present one instruction, sample on the following falling edge
  task automatic issue(input logic [31:0] ins, input logic [127:0] v, input logic [63:0] s,
                       input logic w, input logic t);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src = v; scalar = s; wide = w; track = t;
    @(negedge clk);
    in_valid = 1'b0; instr = '0; src = '0; scalar = '0;
  endtask

  task automatic run_count(input string req, input int op, input int fmt,
                           input logic [127:0] v, input logic [4:0] dst);
    issue(mk(3'(op), 2'(fmt), dst), v, 64'h0, 1'b1, 1'b1);
    chk(req, result, model(op, fmt, v, 64'h0));
    chk(req, {wr_en, resv, out_valid}, 3'b101);
  endtask

  task automatic t_reset;
    chk("R10", {out_valid, wr_en, resv, wr_idx, modset, result}, '0);
  endtask

  task automatic t_lead0;
    issue(mk(3'd3, 2'd0, 5'd1), '0, 64'h0, 1'b1, 1'b0);
    chk("R2", result, {16{8'h08}});
    run_count("R2", 3, 0, 128'h00018040_FF7F0102_0304F00F_80000001, 5'd2);
    run_count("R2", 3, 1, 128'h0000_0001_8000_00FF_7FFF_0100_0010_FFFF, 5'd3);
    run_count("R2", 3, 2, 128'h00000000_00000001_80000000_0000FFFF, 5'd4);
    run_count("R2", 3, 3, 128'h00000000_00000000_00000000_00000001, 5'd5);
  endtask

  task automatic t_lead1;
    issue(mk(3'd2, 2'd1, 5'd1), '1, 64'h0, 1'b1, 1'b0);
    chk("R3", result, {8{16'h0010}});
    run_count("R3", 2, 0, 128'hFF7FFE80_C0010000_E0F0F8FC_FEFFFF00, 5'd6);
    run_count("R3", 2, 2, 128'hFFFFFFFF_FFFF0000_7FFFFFFF_80000000, 5'd7);
    run_count("R3", 2, 3, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_00000000, 5'd8);
  endtask

  task automatic t_pop;
    issue(mk(3'd1, 2'd3, 5'd1), '1, 64'h0, 1'b1, 1'b0);
    chk("R4", result, {2{64'h40}});
    run_count("R4", 1, 0, 128'h0103070F_1F3F7FFF_00805AA5_11224488, 5'd9);
    run_count("R4", 1, 1, 128'hFFFF_0000_AAAA_1234_8001_7FFE_0F0F_0001, 5'd10);
    run_count("R4", 1, 2, 128'hDEADBEEF_00000000_FFFFFFFF_12345678, 5'd11);
  endtask

  task automatic t_fill;
    issue(mk(3'd0, 2'd0, 5'd12), '1, 64'h01234567_89ABCDEF, 1'b0, 1'b0);
    chk("R5", result, {16{8'hEF}});
    issue(mk(3'd0, 2'd1, 5'd12), '0, 64'h01234567_89ABCDEF, 1'b0, 1'b0);
    chk("R5", result, {8{16'hCDEF}});
    issue(mk(3'd0, 2'd2, 5'd12), '0, 64'h01234567_89ABCDEF, 1'b0, 1'b0);
    chk("R5", result, {4{32'h89ABCDEF}});
    issue(mk(3'd0, 2'd3, 5'd13), '0, 64'h01234567_89ABCDEF, 1'b1, 1'b1);
    chk("R5", result, {2{64'h01234567_89ABCDEF}});
    chk("R5", {wr_en, resv, wr_idx}, {1'b1, 1'b0, 5'd13});
  endtask

  task automatic t_resv;
    issue(mk(3'd0, 2'd3, 5'd14), '0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    chk("R6", {out_valid, wr_en, resv}, 3'b101);
    chk("R6", {modset, result}, '0);
  endtask

  task automatic t_undef;
    issue(mk(3'd5, 2'd0, 5'd15), '1, 64'h0, 1'b1, 1'b1);
    chk("R7", {out_valid, wr_en, resv, modset, result}, {1'b1, 162'd0});
    issue({mk(3'd3, 2'd0, 5'd15)} ^ 32'h0000_0001, '0, 64'h0, 1'b1, 1'b1);
    chk("R7", {out_valid, wr_en, resv, modset, result}, {1'b1, 162'd0});
    issue(mk(3'd3, 2'd0, 5'd15) ^ 32'h0020_0000, '0, 64'h0, 1'b1, 1'b1);
    chk("R1", {wr_en, resv}, 2'b00);
  endtask

  task automatic t_track;
    issue(mk(3'd1, 2'd0, 5'd31), '0, 64'h0, 1'b1, 1'b1);
    chk("R9", modset, 32'h8000_0000);
    chk("R1", wr_idx, 5'd31);
    issue(mk(3'd1, 2'd0, 5'd3), '0, 64'h0, 1'b1, 1'b0);
    chk("R9", {wr_en, modset}, {1'b1, 32'h0});
  endtask

  task automatic t_latency;
    issue(mk(3'd1, 2'd0, 5'd9), '1, 64'h0, 1'b1, 1'b1);
    chk("R8", {out_valid, wr_en, wr_idx}, {2'b11, 5'd9});
    @(negedge clk);
    chk("R8", {out_valid, wr_en, resv, modset, result}, '0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src = '0; scalar = '0;
    wide = 1'b0; track = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lead0();
    t_lead1();
    t_pop();
    t_fill();
    t_resv();
    t_undef();
    t_track();
    t_latency();
    finish_run();
  end

  initial begin
    #500us;
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end
endmodule